// File: doc/BRIEF.md
# I2C Bit-Timing Tick Prescaler

This block turns a fast reference clock into the sample tick that an I2C master's bit engine runs on. The reference clock passes through three dividers in a row. The first has a fixed ratio set by a half-period parameter `THP` and a choice of formula. The second divides by a power of two, 2^N. The third divides by a linear factor, M+1. Each output of the chain is a one-cycle pulse on `tick_o`. Ten such ticks make one SCL period. With every tick the block also gives a phase index from 0 to 9. The bit engine uses this index to place the SCL edges and the SDA sample point.

Software picks M and N for the bus speed it wants and writes both in one clock-control byte. Any write restarts the whole chain, so the first tick with the new setting comes one full divide period after the write. When the enable input is low, the chain is held cleared and no ticks come out.

With a first-stage ratio D1, the tick period is D = D1 · 2^N · (M+1) reference cycles. The SCL frequency is therefore f_ref / (10 · D).

Top module: `i2c_tick_prescaler`

## Requirements
- R1: The clock-control byte on `cfg_data_i` is taken in at a rising edge where `cfg_we_i` is high, whether or not the block is enabled. N comes from bits [2:0] and M from bits [6:3]. Bit 7 has no effect on timing.
- R2: With `STAGE1_MODE` = `DIV_DOUBLED`, the first stage divides by 2·(THP+1). With THP=3 this is 8.
- R3: With `STAGE1_MODE` = `DIV_OFFSET`, the first stage divides by THP+2. With THP=24 this is 26.
- R4: While the block is enabled and nothing is written, `tick_o` pulses exactly once every D = D1·2^N·(M+1) cycles, for every M in 0..15 and N in 0..7.
- R5: Each pulse on `tick_o` is high for exactly one cycle.
- R6: While `tick_o` is high, `phase_o` holds the index of that tick. The first tick after a restart has index 0. Later ticks count 1, 2, …, 9 and then wrap to 0. `phase_o` never exceeds 9.
- R7: A write clears every divider stage and the phase. `tick_o` is low in the cycle after the write edge. The first new tick is high in the cycle that follows the D-th rising edge after the write edge.
- R8: While `enable_i` is low, `tick_o` stays 0 and `phase_o` stays 0. After `enable_i` rises, the first tick follows the D-th edge, and its index is 0.
- R9: While `rst_ni` is low, `tick_o` is 0, `phase_o` is 0, and M and N are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the divider chain when high; holds it cleared when low |
| cfg_we_i | input | 1 | Write strobe for the clock-control byte |
| cfg_data_i | input | 8 | Clock-control byte: N in [2:0], M in [6:3], bit 7 unused |
| tick_o | output | 1 | One-cycle sample tick |
| phase_o | output | 4 | Index (0..9) of the most recent tick within the SCL period |

## Verification
The assertions assume that `enable_i`, `cfg_we_i` and `cfg_data_i` change only between rising edges. They also assume that M and N change only through a write, and that a write always clears the counters in the same edge. The range check on each stage counter depends on this. The one-cycle pulse check assumes the first stage never divides by less than 2, which holds for every THP of 0 or more.

The stimulus drives all inputs on the falling edge. It writes new settings both between ticks and in the middle of a divide period. It sets bit 7 in some writes. It drops `enable_i` partway through a period. It covers the smallest and the largest M/N pair, with both first-stage formulas running side by side.

// File: rtl/i2c_presc_pkg.sv
package i2c_presc_pkg;

  typedef enum logic {
    DIV_DOUBLED = 1'b0,   // 2*(THP+1)
    DIV_OFFSET  = 1'b1    // THP+2
  } stage1_mode_e;

  function automatic int unsigned stage1_ratio(stage1_mode_e mode, int unsigned thp);
    return (mode == DIV_OFFSET) ? thp + 2 : 2 * (thp + 1);
  endfunction

endpackage

// File: rtl/presc_fixed_div.sv
module presc_fixed_div
  import i2c_presc_pkg::*;
#(
  parameter stage1_mode_e MODE = DIV_DOUBLED,
  parameter int unsigned  THP  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic carry_o
);

  if (MODE == DIV_OFFSET) begin : g_offset
    localparam int unsigned RATIO = THP + 2;
    localparam int unsigned CW    = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (clr_i)          cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end

    assign carry_o = !clr_i && (cnt_q == LAST);

    AST_OFFSET_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      carry_o |=> cnt_q == '0) else $error("stage1 offset wrap");  // R3
  end else begin : g_doubled
    localparam int unsigned HALF = THP + 1;
    localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);
    logic [CW-1:0] cnt_q;
    logic          half_q;
    logic          half_end;

    assign half_end = (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        half_q <= 1'b0;
      end else if (clr_i) begin
        cnt_q  <= '0;
        half_q <= 1'b0;
      end else if (half_end) begin
        cnt_q  <= '0;
        half_q <= ~half_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end

    assign carry_o = !clr_i && half_end && half_q;

    AST_DOUBLED_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      carry_o |=> (cnt_q == '0 && !half_q)) else $error("stage1 doubled wrap");  // R2
  end

endmodule

// File: rtl/presc_stage_cnt.sv
module presc_stage_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] limit_i,
  output logic         carry_o
);

  logic [W-1:0] cnt_q;
  logic         at_limit;

  assign at_limit = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (adv_i)   cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end

  assign carry_o = !clr_i && adv_i && at_limit;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i) else $error("stage counter beyond limit");  // R4
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> cnt_q == '0) else $error("stage counter wrap");  // R4

endmodule

// File: rtl/presc_phase_cnt.sv
module presc_phase_cnt #(
  parameter int unsigned PHASES = 10,
  localparam int unsigned PW    = $clog2(PHASES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic          tick_o,
  output logic [PW-1:0] phase_o
);

  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] next_q;
  logic [PW-1:0] phase_q;
  logic          tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q  <= '0;
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else if (clr_i) begin
      next_q  <= '0;
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= adv_i;
      if (adv_i) begin
        phase_q <= next_q;
        next_q  <= (next_q == LAST) ? '0 : next_q + 1'b1;
      end
    end
  end

  assign tick_o  = tick_q;
  assign phase_o = phase_q;

  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o) else $error("tick wider than one cycle");  // R5
  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= LAST) else $error("phase out of range");  // R6
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o && !$past(clr_i) |-> $stable(phase_o)) else $error("phase moved without tick");  // R6

endmodule

// File: rtl/i2c_tick_prescaler.sv
module i2c_tick_prescaler
  import i2c_presc_pkg::*;
#(
  parameter stage1_mode_e STAGE1_MODE = DIV_DOUBLED,
  parameter int unsigned  THP         = 3,
  parameter int unsigned  M_W         = 4,
  parameter int unsigned  N_W         = 3,
  parameter int unsigned  PHASES      = 10,
  localparam int unsigned CFG_W       = M_W + N_W + 1,
  localparam int unsigned PH_W        = $clog2(PHASES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  output logic             tick_o,
  output logic [PH_W-1:0]  phase_o
);

  localparam int unsigned P2_W = (1 << N_W) - 1;
  localparam logic [P2_W-1:0] P2_ONE = P2_W'(1);

  logic [M_W-1:0]  cfg_m_q;
  logic [N_W-1:0]  cfg_n_q;
  logic [P2_W-1:0] p2_limit;
  logic            clr;
  logic            c1, c2, c3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_m_q <= '0;
      cfg_n_q <= '0;
    end else if (cfg_we_i) begin
      cfg_n_q <= cfg_data_i[N_W-1:0];
      cfg_m_q <= cfg_data_i[N_W +: M_W];
    end
  end

  assign clr      = !enable_i || cfg_we_i;
  // 2^N - 1; N = full width wraps to all ones
  assign p2_limit = (P2_ONE << cfg_n_q) - P2_ONE;

  presc_fixed_div #(.MODE(STAGE1_MODE), .THP(THP)) i_stage1 (
    .clk_i, .rst_ni, .clr_i(clr), .carry_o(c1)
  );

  presc_stage_cnt #(.W(P2_W)) i_stage_pow2 (
    .clk_i, .rst_ni, .clr_i(clr), .adv_i(c1), .limit_i(p2_limit), .carry_o(c2)
  );

  presc_stage_cnt #(.W(M_W)) i_stage_lin (
    .clk_i, .rst_ni, .clr_i(clr), .adv_i(c2), .limit_i(cfg_m_q), .carry_o(c3)
  );

  presc_phase_cnt #(.PHASES(PHASES)) i_phase (
    .clk_i, .rst_ni, .clr_i(clr), .adv_i(c3), .tick_o, .phase_o
  );

  AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!tick_o && phase_o == '0)) else $error("tick while disabled");  // R8
  AST_CFG_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (!tick_o && phase_o == '0)) else $error("write did not restart");  // R7
  AST_CFG_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_m_q == $past(cfg_data_i[N_W +: M_W])) else $error("M not latched");  // R1

endmodule

// File: tb/test_i2c_tick_prescaler.sv
module test_i2c_tick_prescaler;
  import i2c_presc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int D1_A = 8;   // doubled, THP=3
  localparam int D1_B = 26;  // offset, THP=24

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       we = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       tick_a, tick_b;
  logic [3:0] ph_a, ph_b;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R9";

  int m_m = 0, m_n = 0;
  int cnt_a = 0, nidx_a = 0, et_a = 0, ep_a = 0;
  int cnt_b = 0, nidx_b = 0, et_b = 0, ep_b = 0;
  int ticks_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tick_prescaler #(.STAGE1_MODE(DIV_DOUBLED), .THP(3)) i_i2c_tick_prescaler (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .cfg_we_i(we), .cfg_data_i(cfg),
    .tick_o(tick_a), .phase_o(ph_a)
  );

  i2c_tick_prescaler #(.STAGE1_MODE(DIV_OFFSET), .THP(24)) i_i2c_tick_prescaler_b (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .cfg_we_i(we), .cfg_data_i(cfg),
    .tick_o(tick_b), .phase_o(ph_b)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int da, db;
    bit clear;
    if (!rst_n) begin
      m_m = 0; m_n = 0;
    end else if (we) begin
      m_n = cfg[2:0];
      m_m = cfg[6:3];
    end
    clear = !rst_n || !en || we;
    da = D1_A * (2 ** m_n) * (m_m + 1);
    db = D1_B * (2 ** m_n) * (m_m + 1);
    if (clear) begin
      cnt_a = 0; nidx_a = 0; et_a = 0; ep_a = 0;
      cnt_b = 0; nidx_b = 0; et_b = 0; ep_b = 0;
    end else begin
      if (cnt_a == da - 1) begin
        et_a = 1; ep_a = nidx_a; nidx_a = (nidx_a + 1) % 10; cnt_a = 0;
      end else begin
        et_a = 0; cnt_a++;
      end
      if (cnt_b == db - 1) begin
        et_b = 1; ep_b = nidx_b; nidx_b = (nidx_b + 1) % 10; cnt_b = 0;
      end else begin
        et_b = 0; cnt_b++;
      end
    end
  end

  always @(negedge clk) begin
    checks += 4;
    if (tick_a) ticks_seen++;
    if (tick_a !== 1'(et_a)) begin
      errors++;
      $display("FAIL R2 %s tick_a: actual %b expected %0d at %0t", cur_req, tick_a, et_a, $time);
    end
    if (ph_a !== 4'(ep_a)) begin
      errors++;
      $display("FAIL R2 %s phase_a: actual %0d expected %0d at %0t", cur_req, ph_a, ep_a, $time);
    end
    if (tick_b !== 1'(et_b)) begin
      errors++;
      $display("FAIL R3 %s tick_b: actual %b expected %0d at %0t", cur_req, tick_b, et_b, $time);
    end
    if (ph_b !== 4'(ep_b)) begin
      errors++;
      $display("FAIL R3 %s phase_b: actual %0d expected %0d at %0t", cur_req, ph_b, ep_b, $time);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input int m, input int n, input bit b7);
    @(negedge clk);
    we  = 1'b1;
    cfg = {b7, 4'(m), 3'(n)};
    @(negedge clk);
    we  = 1'b0;
  endtask

  initial begin
    run(4);                         // R9: reset state compared each cycle
    rst_n = 1'b1;
    run(2);
    cur_req = "R4";
    en = 1'b1;
    run(200);                       // M=0,N=0 default after reset
    write_cfg(1, 0, 1'b0);
    run(600);
    cur_req = "R6";
    write_cfg(0, 0, 1'b0);
    run(320);
    cur_req = "R1";
    write_cfg(2, 1, 1'b1);          // bit 7 set, no timing effect
    run(1600);
    cur_req = "R7";
    run(23);
    write_cfg(2, 1, 1'b0);          // mid-period rewrite restarts chain
    run(400);
    cur_req = "R8";
    run(17);
    en = 1'b0;
    run(100);
    write_cfg(1, 2, 1'b0);          // latched while disabled
    run(30);
    en = 1'b1;
    run(900);
    cur_req = "R5";
    write_cfg(3, 0, 1'b0);
    run(1100);
    cur_req = "R4";
    write_cfg(15, 7, 1'b0);         // largest divide
    run(16384 * 2 + 20);
    write_cfg(15, 7, 1'b0);
    run(53248 - 10);
    checks++;
    if (ticks_seen < 20) begin
      errors++;
      $display("FAIL R4 tick count: actual %0d expected >= 20", ticks_seen);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule